// File: doc/BRIEF.md
# Multi-channel periodic interrupt timer

This block holds four independent countdown timers behind a single-cycle 32-bit register port. Software programs a reload value per channel, starts the channel through its control register, and then receives a periodic event. Each expiry raises a sticky time-out flag and emits a one-cycle trigger pulse. The flag also drives that channel's own level interrupt line when the channel's interrupt enable is set.

The register port has no handshake. A write is taken on the rising clock edge whenever `we_i` is high. Read data is a combinational function of `addr_i`. Each channel owns a 16-byte window starting at 0x100. Within that window there are four words: the reload value, the live count, the control bits and the time-out flag. The flag is write-one-to-clear.

Top module: `ptimer_bank`

## Requirements
- R1: After reset, every register of every channel reads 0, and `irq_o` and `trig_o` are all low.
- R2: Register map and field layout:
  - Channel n occupies addresses 0x100 + 0x10*n.
  - Offset +0x0 holds the reload value (read/write).
  - Offset +0x4 holds the current count. It is read-only, and writes to it are ignored.
  - Offset +0x8 is control. Bit 0 is run and bit 1 is interrupt enable. Its other bits read 0.
  - Offset +0xC is the flag register. Bit 0 is the time-out flag. Its other bits read 0.
  - Misaligned addresses and addresses outside 0x100–0x13F read 0 and are not written.
- R3: A control write that changes run from 0 to 1 loads the count with the reload value on that clock edge. The count then falls by one on every following clock.
- R4: On the clock after the count reaches 0 while running, the channel does three things at once:
  - it reloads the count,
  - it sets the time-out flag,
  - it drives its `trig_o` bit high for exactly one cycle.

  The trigger period is therefore reload value + 1 clocks.
- R5: Writing 1 to flag bit 0 clears the flag. Writing 0 to that bit leaves the flag unchanged, and only a clear write lowers it.
- R6: If a time-out and a clear write fall on the same clock edge, the flag ends up 1.
- R7: `irq_o[n]` is high exactly when channel n's flag and interrupt enable are both 1. Setting the enable while the flag is already 1 raises the line on that same clock edge.
- R8: Writing the reload value while the channel runs does not change the ongoing count. The new value is used at the next reload.
- R9: Clearing run freezes the count at its present value. Setting run again restarts the count from the reload value.
- R10: The channels are independent. Activity on one channel never changes another channel's count, flag or trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write strobe, taken on the rising edge |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| irq_o | output | 4 | Per-channel level interrupt |
| trig_o | output | 4 | Per-channel one-cycle trigger pulse |

## Verification
A wrong count or reload shows up first on `trig_o`. A pulse that arrives one cycle early or late, or a pulse stretched to two cycles, is visible on the very next expiry. The bench therefore compares every pulse against its exact expected cycle rather than only counting pulses. A mishandled flag stays hidden until it is read back or until the interrupt enable is set. For that reason the flag is read right after each clear, after each write of 0, and after the clear that collides with an expiry. The interrupt line is sampled on the cycle after the enable is written.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  typedef enum logic [1:0] {
    REG_LOAD = 2'd0,
    REG_CNT  = 2'd1,
    REG_CTRL = 2'd2,
    REG_FLAG = 2'd3
  } reg_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_IE_BIT  = 1;
  localparam int FLAG_BIT     = 0;
  localparam int WIN_LSB      = 4;  // 0x10 bytes per channel
endpackage

// File: rtl/ptimer_decode.sv
module ptimer_decode
  import ptimer_pkg::*;
#(
  parameter int              N_CH      = 4,
  parameter int              AW        = 12,
  parameter int              CH_W      = (N_CH > 1) ? $clog2(N_CH) : 1,
  parameter logic [AW-1:0]   BASE_ADDR = 12'h100
) (
  input  logic [AW-1:0]   addr_i,
  output logic            hit_o,
  output logic [CH_W-1:0] ch_o,
  output reg_e            reg_o
);
  localparam int TOP_LSB = WIN_LSB + CH_W;

  assign ch_o  = addr_i[WIN_LSB +: CH_W];
  assign reg_o = reg_e'(addr_i[3:2]);
  assign hit_o = (addr_i[AW-1:TOP_LSB] == BASE_ADDR[AW-1:TOP_LSB]) &&
                 (addr_i[1:0] == 2'b00) && (int'(ch_o) < N_CH);
endmodule

// File: rtl/ptimer_channel.sv
module ptimer_channel
  import ptimer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_load_i,
  input  logic          wr_ctrl_i,
  input  logic          wr_flag_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] load_o,
  output logic [DW-1:0] cnt_o,
  output logic          run_o,
  output logic          ie_o,
  output logic          flag_o,
  output logic          irq_o,
  output logic          trig_o
);
  logic [DW-1:0] load_q, cnt_q;
  logic          run_q, ie_q, flag_q, trig_q;
  logic          start, expire, clr;

  assign start  = wr_ctrl_i && wdata_i[CTRL_RUN_BIT] && !run_q;
  assign expire = run_q && (cnt_q == '0);
  assign clr    = wr_flag_i && wdata_i[FLAG_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      if (wr_load_i) load_q <= wdata_i;
      if (wr_ctrl_i) begin
        run_q <= wdata_i[CTRL_RUN_BIT];
        ie_q  <= wdata_i[CTRL_IE_BIT];
      end
      if (start)       cnt_q <= load_q;
      else if (expire) cnt_q <= load_q;
      else if (run_q)  cnt_q <= cnt_q - 1'b1;
      // expiry beats a simultaneous clear
      if (expire)   flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
      trig_q <= expire;
    end
  end

  assign load_o = load_q;
  assign cnt_o  = cnt_q;
  assign run_o  = run_q;
  assign ie_o   = ie_q;
  assign flag_o = flag_q;
  assign trig_o = trig_q;
  assign irq_o  = flag_q & ie_q;

  p_expire_flags_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q == '0) |=> (trig_q && flag_q && cnt_q == $past(load_q)));
  p_flag_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr) |=> flag_q);
  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && clr) |=> flag_q);
  p_irq_needs_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_q |-> !irq_o);
  p_stopped_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !start) |=> $stable(cnt_q));
endmodule

// File: rtl/ptimer_bank.sv
module ptimer_bank
  import ptimer_pkg::*;
#(
  parameter int            N_CH      = 4,
  parameter int            AW        = 12,
  parameter int            DW        = 32,
  parameter logic [AW-1:0] BASE_ADDR = 12'h100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic [N_CH-1:0] irq_o,
  output logic [N_CH-1:0] trig_o
);
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic            hit;
  logic [CH_W-1:0] ch;
  reg_e            reg_sel;

  logic [DW-1:0]   load_w [N_CH];
  logic [DW-1:0]   cnt_w  [N_CH];
  logic [N_CH-1:0] run_w, ie_w, flag_w;
  logic [N_CH-1:0] wr_load, wr_ctrl, wr_flag;

  ptimer_decode #(.N_CH(N_CH), .AW(AW), .CH_W(CH_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit),
    .ch_o   (ch),
    .reg_o  (reg_sel)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic sel;
    assign sel        = we_i && hit && (ch == CH_W'(g));
    assign wr_load[g] = sel && (reg_sel == REG_LOAD);
    assign wr_ctrl[g] = sel && (reg_sel == REG_CTRL);
    assign wr_flag[g] = sel && (reg_sel == REG_FLAG);

    ptimer_channel #(.DW(DW)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_load_i (wr_load[g]),
      .wr_ctrl_i (wr_ctrl[g]),
      .wr_flag_i (wr_flag[g]),
      .wdata_i   (wdata_i),
      .load_o    (load_w[g]),
      .cnt_o     (cnt_w[g]),
      .run_o     (run_w[g]),
      .ie_o      (ie_w[g]),
      .flag_o    (flag_w[g]),
      .irq_o     (irq_o[g]),
      .trig_o    (trig_o[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      unique case (reg_sel)
        REG_LOAD: rdata_o = load_w[ch];
        REG_CNT:  rdata_o = cnt_w[ch];
        REG_CTRL: begin
          rdata_o[CTRL_RUN_BIT] = run_w[ch];
          rdata_o[CTRL_IE_BIT]  = ie_w[ch];
        end
        REG_FLAG: rdata_o[FLAG_BIT] = flag_w[ch];
        default:  rdata_o = '0;
      endcase
    end
  end

  p_one_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_load, wr_ctrl, wr_flag}));
  p_no_write_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |-> ({wr_load, wr_ctrl, wr_flag} == '0));
endmodule

// File: tb/ptimer_bank_test.sv
module ptimer_bank_test;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] irq, trig;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int exp_q [N][$];

  ptimer_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .trig_o(trig)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [11:0] ra(int c, int off);
    return 12'(32'h100 + 32'h10 * c + off);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic wait_cyc(int n);
    while (cyc < n) begin @(posedge clk); #1; end
  endtask

  task automatic drain(int c);
    while (exp_q[c].size() != 0) @(posedge clk);
  endtask

  // monitor: every trigger pulse must match the next expected cycle
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < N; c++) begin
        if (trig[c]) begin
          if (exp_q[c].size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R4/R10: ch%0d unexpected trigger at cycle %0d expected none", c, cyc);
          end else begin
            chk($sformatf("R4 ch%0d trigger cycle", c), 32'(cyc), 32'(exp_q[c].pop_front()));
          end
        end
      end
    end
  end

  task automatic run_all();
    int k, k2, k3;
    // R1 reset state
    for (int c = 0; c < N; c++)
      for (int r = 0; r < 4; r++)
        rd_chk("R1 reset reg", ra(c, 4 * r), 32'h0);
    chk("R1 irq reset", 32'(irq), 32'h0);
    chk("R1 trig reset", 32'(trig), 32'h0);

    // R2 map and field widths
    wr(ra(1, 0), 32'h0000_ABCD);
    rd_chk("R2 load readback", ra(1, 0), 32'h0000_ABCD);
    wr(ra(1, 4), 32'h55);
    rd_chk("R2 count read-only", ra(1, 4), 32'h0);
    wr(12'h000, 32'hFFFF_FFFF);
    rd_chk("R2 outside window", 12'h000, 32'h0);
    wr(12'h102, 32'h1234);
    rd_chk("R2 misaligned not written", ra(0, 0), 32'h0);
    rd_chk("R2 above window", 12'h140, 32'h0);

    // R3 start and countdown, R9 freeze and restart, using ch3
    wr(ra(3, 0), 32'd1000);
    wr(ra(3, 8), 32'hFFFF_FFFF);
    rd_chk("R2 ctrl field width", ra(3, 8), 32'h3);
    rd_chk("R3 start loads count", ra(3, 4), 32'd1000);
    repeat (3) @(posedge clk);
    #1 rd_chk("R3 counts down", ra(3, 4), 32'd997);
    wr(ra(3, 12), 32'hFFFF_FFFE);
    rd_chk("R2 flag field width", ra(3, 12), 32'h0);
    wr(ra(3, 8), 32'h0);
    begin
      logic [31:0] v;
      rd(ra(3, 4), v);
      repeat (5) @(posedge clk);
      #1 rd_chk("R9 stopped count frozen", ra(3, 4), v);
    end
    wr(ra(3, 8), 32'h1);
    rd_chk("R9 restart from load", ra(3, 4), 32'd1000);
    wr(ra(3, 8), 32'h0);

    // R4 periodic expiry on ch0, period load+1
    wr(ra(0, 0), 32'd5);
    wr(ra(0, 8), 32'h1);
    k = cyc;
    exp_q[0].push_back(k + 6);
    exp_q[0].push_back(k + 12);
    exp_q[0].push_back(k + 18);
    drain(0);
    wr(ra(0, 8), 32'h0);
    rd_chk("R4 flag set on expiry", ra(0, 12), 32'h1);
    chk("R7 irq low with enable clear", 32'(irq[0]), 32'h0);
    wr(ra(0, 12), 32'h0);
    rd_chk("R5 write 0 keeps flag", ra(0, 12), 32'h1);
    wr(ra(0, 8), 32'h2);
    chk("R7 immediate irq on enable", 32'(irq[0]), 32'h1);
    wr(ra(0, 12), 32'h1);
    rd_chk("R5 write 1 clears flag", ra(0, 12), 32'h0);
    chk("R7 irq drops with flag", 32'(irq[0]), 32'h0);

    // R6 clear collides with expiry
    wr(ra(0, 8), 32'h1);
    k = cyc;
    exp_q[0].push_back(k + 6);
    exp_q[0].push_back(k + 12);
    wait_cyc(k + 5);
    wr(ra(0, 12), 32'h1);
    rd_chk("R6 set wins over clear", ra(0, 12), 32'h1);
    drain(0);
    wr(ra(0, 8), 32'h0);
    wr(ra(0, 12), 32'h1);

    // R8 reload change while running on ch1
    wr(ra(1, 0), 32'd6);
    wr(ra(1, 8), 32'h1);
    k = cyc;
    exp_q[1].push_back(k + 7);
    exp_q[1].push_back(k + 10);
    exp_q[1].push_back(k + 13);
    wait_cyc(k + 2);
    wr(ra(1, 0), 32'd2);
    rd_chk("R8 count undisturbed", ra(1, 4), 32'd3);
    drain(1);
    wr(ra(1, 8), 32'h0);

    // R10 two channels at once
    wr(ra(2, 0), 32'd4);
    wr(ra(3, 0), 32'd7);
    wr(ra(2, 8), 32'h1);
    k2 = cyc;
    wr(ra(3, 8), 32'h1);
    k3 = cyc;
    for (int i = 1; i <= 3; i++) begin
      exp_q[2].push_back(k2 + 5 * i);
      exp_q[3].push_back(k3 + 8 * i);
    end
    drain(2);
    wr(ra(2, 8), 32'h0);
    drain(3);
    wr(ra(3, 8), 32'h0);
    rd_chk("R10 ch2 flag", ra(2, 12), 32'h1);
    rd_chk("R10 ch3 flag", ra(3, 12), 32'h1);
    rd_chk("R10 ch0 flag untouched", ra(0, 12), 32'h0);
    chk("R10 no irq without enable", 32'(irq), 32'h0);
    repeat (10) @(posedge clk);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule